// File: doc/BRIEF.md
# Double-Buffered DAC Input Stage with Power Sequencer

This block is the digital core in front of a 10-bit parallel-input current-steering converter. A data word is taken into an input latch on a rising clock edge while the active-low select is low. On the next rising edge it moves into the converter register that drives the current array. The code therefore reaches the array two edges after it was presented.

Two mode pins choose among three power states. In shutdown everything analog is off. In standby the reference and control amplifier stay biased and the current array is off. In normal operation everything is on. The output is high impedance in shutdown and standby. When the block leaves either low-power state, a cycle counter holds the output enable and the ready flag low until the analog side has had time to settle. That wait is short after standby and long after a cold start. The converter code survives standby, so the output comes back at its old value. Shutdown clears it. A separate active-low select chooses the on-chip reference or an external one.

Top module: `dac_frontend`

## Requirements
- R1: When the select is low during normal operation, the word on `data_i` is captured on a rising edge and appears on `code_o` after the next rising edge, so the latency is two edges. `data_i[9]` is the MSB.
- R2: While `cs_ni` is high, the input latch keeps its value, and `code_o` stays at the last captured word whatever `data_i` does.
- R3: When `pwr_down_i` is 1 at a rising edge, the block is in shutdown after that edge, whatever `dac_en_i` is. In shutdown `ref_en_o`, `amp_en_o`, `array_en_o`, `out_en_o` and `ready_o` are all 0.
- R4: When `pwr_down_i` is 0 and `dac_en_i` is 0 at a rising edge, the block is in standby after that edge. In standby `ref_en_o` and `amp_en_o` are 1, while `array_en_o` and `out_en_o` are 0.
- R5: `out_en_o` (1 = output driven, 0 = high impedance) and `ready_o` are 1 only in normal operation. Whenever they are 1, the reference, the amplifier and the array are all enabled.
- R6: Leaving standby with `pwr_down_i` 0 and `dac_en_i` 1 holds `out_en_o` and `ready_o` at 0 until the Nth rising edge, counted from and including the edge that samples the request. They rise on that edge. N = ceil(CLK_HZ × STBY_WAKE_NS / 1e9), which is 20 at the defaults.
- R7: After a shutdown, the first wake takes M edges, where M = ceil(CLK_HZ × SHDN_WAKE_NS / 1e9), which is 2000 at the defaults. This holds even if standby is passed through on the way. Later wakes out of standby take N.
- R8: The converter code is frozen while the block is not in normal operation. Data presented in standby is ignored, and after a wake from standby `code_o` equals the code held before standby.
- R9: Shutdown clears both registers. From the edge that samples `pwr_down_i` = 1, `code_o` is 0, and it is still 0 when the next wake completes.
- R10: `int_ref_en_o` is 1 exactly when the reference is powered and `ref_sel_ni` is 0. It is 0 in shutdown or when `ref_sel_ni` is 1.
- R11: During and after reset the block is in shutdown, with `code_o` = 0 and every enable and `ready_o` at 0.
- R12: `array_en_o` is 1 during the wake count and in normal operation, so the array settles before the output is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | DATA_W | Parallel input word, MSB first |
| cs_ni | input | 1 | Active-low select; enables input capture |
| pwr_down_i | input | 1 | 1 requests shutdown |
| dac_en_i | input | 1 | With pwr_down_i = 0: 1 run, 0 standby |
| ref_sel_ni | input | 1 | 0 selects the on-chip reference, 1 selects an external one |
| code_o | output | DATA_W | Code to the current array |
| out_en_o | output | 1 | 1 drives the output, 0 leaves it high impedance |
| ref_en_o | output | 1 | Reference bias enable |
| amp_en_o | output | 1 | Control amplifier enable |
| array_en_o | output | 1 | Current array enable |
| int_ref_en_o | output | 1 | On-chip reference enable |
| ready_o | output | 1 | Output settled and valid |

## Verification
The checker treats `pwr_down_i` and `dac_en_i` as already synchronous to `clk_i`: each property relates their value at one edge to the state after it. The bench therefore changes every input only on falling edges. The hold property on `code_o` assumes that nothing but the shutdown clear can change the converter register outside normal operation. The bench raises the select before it leaves normal operation, so the latch holds no pending word across a power-mode change, and every expected code is known before the mode changes.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;

  typedef enum logic [1:0] {
    PM_SHDN = 2'd0,
    PM_STBY = 2'd1,
    PM_WAKE = 2'd2,
    PM_RUN  = 2'd3
  } pmode_e;

  typedef enum logic [1:0] {
    RQ_SHDN = 2'd0,
    RQ_STBY = 2'd1,
    RQ_ON   = 2'd2
  } preq_e;

  // ceil(hz * ns / 1e9), computed in 64 bits
  function automatic int unsigned ns_to_cycles(input int unsigned hz, input int unsigned ns);
    longint unsigned prod;
    prod = longint'(hz) * longint'(ns);
    return 32'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

endpackage

// File: rtl/dac_fe_pipe.sv
module dac_fe_pipe #(
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              run_i,
  input  logic              cs_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] code_o
);

  logic [DATA_W-1:0] in_q;
  logic [DATA_W-1:0] dac_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      dac_q <= '0;
    end else if (clear_i) begin
      in_q  <= '0;
      dac_q <= '0;
    end else if (run_i) begin
      if (!cs_ni) in_q <= data_i;
      dac_q <= in_q;
    end
  end

  assign code_o = dac_q;

endmodule

// File: rtl/dac_fe_wake_timer.sv
module dac_fe_wake_timer #(
  parameter int unsigned SHORT_CYC = 20,
  parameter int unsigned LONG_CYC  = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic long_i,
  input  logic run_i,
  output logic done_o
);

  localparam int unsigned CW = $clog2(LONG_CYC + 1);
  localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_CYC - 1);
  localparam logic [CW-1:0] LONG_LD  = CW'(LONG_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= long_i ? LONG_LD : SHORT_LD;
    end else if (run_i && cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign done_o = run_i && (cnt_q == CW'(1));

endmodule

// File: rtl/dac_fe_pwr_fsm.sv
module dac_fe_pwr_fsm
  import dac_fe_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pd_i,
  input  logic   en_i,
  input  logic   done_i,
  output pmode_e state_o,
  output logic   load_o,
  output logic   long_o,
  output logic   shdn_req_o
);

  preq_e  req;
  pmode_e state_q, state_d;
  logic   warm_q;

  always_comb begin
    if (pd_i)      req = RQ_SHDN;
    else if (en_i) req = RQ_ON;
    else           req = RQ_STBY;
  end

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    unique case (req)
      RQ_SHDN: state_d = PM_SHDN;
      RQ_STBY: state_d = PM_STBY;
      RQ_ON: begin
        if (state_q == PM_SHDN || state_q == PM_STBY) begin
          state_d = PM_WAKE;
          load_o  = 1'b1;
        end else if (state_q == PM_WAKE && done_i) begin
          state_d = PM_RUN;
        end
      end
      default: state_d = PM_SHDN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PM_SHDN;
      warm_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_d == PM_SHDN)                          warm_q <= 1'b0;
      else if (state_q == PM_WAKE && state_d == PM_RUN) warm_q <= 1'b1;
    end
  end

  assign state_o    = state_q;
  assign long_o     = !warm_q;
  assign shdn_req_o = (req == RQ_SHDN) || (state_q == PM_SHDN);

endmodule

// File: rtl/dac_frontend.sv
module dac_frontend
  import dac_fe_pkg::*;
#(
  parameter int unsigned DATA_W        = 10,
  parameter int unsigned CLK_HZ        = 40_000_000,
  parameter int unsigned STBY_WAKE_NS  = 500,
  parameter int unsigned SHDN_WAKE_NS  = 50_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              cs_ni,
  input  logic              pwr_down_i,
  input  logic              dac_en_i,
  input  logic              ref_sel_ni,
  output logic [DATA_W-1:0] code_o,
  output logic              out_en_o,
  output logic              ref_en_o,
  output logic              amp_en_o,
  output logic              array_en_o,
  output logic              int_ref_en_o,
  output logic              ready_o
);

  localparam int unsigned STBY_CYC = ns_to_cycles(CLK_HZ, STBY_WAKE_NS);
  localparam int unsigned SHDN_CYC = ns_to_cycles(CLK_HZ, SHDN_WAKE_NS);

  pmode_e state;
  logic   load, long_wait, done, shdn_req, running;

  dac_fe_pwr_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pd_i       (pwr_down_i),
    .en_i       (dac_en_i),
    .done_i     (done),
    .state_o    (state),
    .load_o     (load),
    .long_o     (long_wait),
    .shdn_req_o (shdn_req)
  );

  dac_fe_wake_timer #(
    .SHORT_CYC (STBY_CYC),
    .LONG_CYC  (SHDN_CYC)
  ) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .long_i (long_wait),
    .run_i  (state == PM_WAKE),
    .done_o (done)
  );

  assign running = (state == PM_RUN);

  dac_fe_pipe #(
    .DATA_W (DATA_W)
  ) i_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (shdn_req),
    .run_i   (running),
    .cs_ni   (cs_ni),
    .data_i  (data_i),
    .code_o  (code_o)
  );

  assign ref_en_o     = (state != PM_SHDN);
  assign amp_en_o     = (state != PM_SHDN);
  assign array_en_o   = (state == PM_WAKE) || running;
  assign out_en_o     = running;
  assign ready_o      = running;
  assign int_ref_en_o = ref_en_o && !ref_sel_ni;

endmodule

// File: rtl/dac_frontend_chk.sv
module dac_frontend_chk #(
  parameter int unsigned DATA_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pwr_down_i,
  input logic              dac_en_i,
  input logic [DATA_W-1:0] code_o,
  input logic              out_en_o,
  input logic              ref_en_o,
  input logic              amp_en_o,
  input logic              array_en_o,
  input logic              int_ref_en_o,
  input logic              ready_o
);

  a_r3_shdn_all_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_down_i |=> !ref_en_o && !amp_en_o && !array_en_o && !out_en_o && !ready_o);

  a_r4_stby_bias_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_down_i && !dac_en_i) |=> ref_en_o && amp_en_o && !array_en_o && !out_en_o);

  a_r5_oe_needs_power: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_en_o || ready_o) |-> (ref_en_o && amp_en_o && array_en_o));

  a_r8_code_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_en_o && !pwr_down_i) |=> $stable(code_o));

  a_r9_shdn_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_down_i |=> (code_o == '0));

  a_r10_int_ref_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_en_o |-> !int_ref_en_o);

  a_r12_array_before_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_en_o) |-> $past(array_en_o));

endmodule

bind dac_frontend dac_frontend_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pwr_down_i   (pwr_down_i),
  .dac_en_i     (dac_en_i),
  .code_o       (code_o),
  .out_en_o     (out_en_o),
  .ref_en_o     (ref_en_o),
  .amp_en_o     (amp_en_o),
  .array_en_o   (array_en_o),
  .int_ref_en_o (int_ref_en_o),
  .ready_o      (ready_o)
);

// File: tb/test_dac_frontend.sv
module test_dac_frontend;

  localparam int DW     = 10;
  localparam int STBY_N = 20;    // 40 MHz * 500 ns
  localparam int SHDN_N = 2000;  // 40 MHz * 50 us

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] data = '0;
  logic          cs_n = 1'b1;
  logic          pd = 1'b1;
  logic          den = 1'b0;
  logic          rsel_n = 1'b0;
  logic [DW-1:0] code;
  logic          oe, ref_en, amp_en, arr_en, iref_en, rdy;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dac_frontend i_dac_frontend (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .data_i       (data),
    .cs_ni        (cs_n),
    .pwr_down_i   (pd),
    .dac_en_i     (den),
    .ref_sel_ni   (rsel_n),
    .code_o       (code),
    .out_en_o     (oe),
    .ref_en_o     (ref_en),
    .amp_en_o     (amp_en),
    .array_en_o   (arr_en),
    .int_ref_en_o (iref_en),
    .ready_o      (rdy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic edge_sample();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 code", code, 0);
    chk("R11 enables", {ref_en, amp_en, arr_en, oe, rdy}, 0);
    chk("R10 iref off in shutdown", iref_en, 0);
    @(negedge clk) rst_n = 1'b1;
    edge_sample();
    chk("R11 stays shutdown", {ref_en, oe}, 0);
  endtask

  // wake with expected edge count n; request applied on a falling edge
  task automatic t_wake(input int n, input string req);
    @(negedge clk);
    pd = 1'b0; den = 1'b1;
    repeat (n - 1) @(posedge clk);
    #1;
    chk({req, " oe low before count"}, {oe, rdy}, 0);
    chk("R12 array on during wake", arr_en, 1);
    edge_sample();
    chk({req, " oe/ready at count"}, {oe, rdy}, 2'b11);
  endtask

  task automatic t_stream();
    @(negedge clk); cs_n = 1'b0; data = 10'h2A5;
    edge_sample();
    chk("R1 not yet through", code, 0);
    @(negedge clk); data = 10'h15A;
    edge_sample();
    chk("R1 first word", code, 10'h2A5);
    @(negedge clk); data = 10'h3FF;
    edge_sample();
    chk("R1 second word", code, 10'h15A);
    @(negedge clk); cs_n = 1'b1; data = 10'h001;
    edge_sample();
    chk("R1 msb word", code, 10'h3FF);
    edge_sample();
    chk("R2 held cs high", code, 10'h3FF);
    @(negedge clk); data = 10'h0F0;
    edge_sample(); edge_sample();
    chk("R2 still held", code, 10'h3FF);
  endtask

  task automatic t_standby();
    @(negedge clk); den = 1'b0;
    edge_sample();
    chk("R4 ref/amp on", {ref_en, amp_en}, 2'b11);
    chk("R4 array/oe off", {arr_en, oe}, 0);
    chk("R5 ready off", rdy, 0);
    @(negedge clk); cs_n = 1'b0; data = 10'h055;
    repeat (5) edge_sample();
    chk("R8 standby data ignored", code, 10'h3FF);
    @(negedge clk); cs_n = 1'b1;
  endtask

  task automatic t_shutdown();
    @(negedge clk); pd = 1'b1; den = 1'b1;
    edge_sample();
    chk("R3 all off", {ref_en, amp_en, arr_en, oe, rdy}, 0);
    chk("R9 cleared", code, 0);
    chk("R10 iref off", iref_en, 0);
  endtask

  task automatic t_cold_via_standby();
    @(negedge clk); pd = 1'b0; den = 1'b0;
    edge_sample();
    chk("R4 standby after shutdown", {ref_en, arr_en}, 2'b10);
    repeat (30) @(posedge clk);
    t_wake(SHDN_N, "R7 cold via standby");
    chk("R9 code zero after wake", code, 0);
  endtask

  task automatic t_ref();
    @(negedge clk); rsel_n = 1'b0; #1;
    chk("R10 internal selected", iref_en, 1);
    rsel_n = 1'b1; #1;
    chk("R10 external selected", iref_en, 0);
  endtask

  initial begin
    t_reset();
    t_wake(SHDN_N, "R7 cold start");
    chk("R10 iref on", iref_en, 1);
    t_stream();
    t_standby();
    t_wake(STBY_N, "R6 standby exit");
    chk("R8 code restored", code, 10'h3FF);
    t_shutdown();
    t_cold_via_standby();
    t_ref();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #80000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule